// File: doc/BRIEF.md
# Core Status Flag and Interrupt Aggregator

This block gathers the status events of a random-number core into one level interrupt line. Three sticky flags record a completed operation, a failed deterministic self-test and a failed entropy-health test. Each flag has its own enable bit and its own clear bit in one control word. The enabled flags are ORed into a core interrupt bit.

That core bit shares a two-bit interrupt status word with a bus slave-error bit. Both status bits pass through a mask that software cannot write directly. Software only sets mask bits through a disable strobe and clears them through an enable strobe. The interrupt output is registered. Bus decode is reduced to one write strobe and data word per register. The events arrive as one-cycle pulses. The two test-failure events are accepted only while the noise source is active.

Top module: `irq_agg_top`

## Requirements
- R1: After reset all flags and enables are 0, the status word is 0, the mask is 2'b11 and `irq_o` is 0.
- R2: A control write loads the enables from data bits 0 (done), 1 (test failure) and 2 (health failure). A 1 in data bit 3, 4 or 5 clears the done, test-failure or health-failure flag respectively.
- R3: Status bit 0 becomes the OR over the three flags of (flag AND enable) on the same clock edge that updates the flags and enables. Writing 1 to status bit 0 does not clear it while an enabled flag is still set.
- R4: A `slverr_i` pulse sets status bit 1. Writing 1 to status bit 1 clears it. A pulse in the same cycle as that write leaves the bit set.
- R5: The mask resets to 2'b11 and changes only through two strobes. A 1 in the enable-strobe data clears that mask bit, and a 1 in the disable-strobe data sets it. If both name the same bit in one cycle, the bit ends up set.
- R6: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. It is registered and changes on the same edge as the status and mask bits that cause the change.
- R7: A done event always sets the done flag. A test-failure or health-failure event is ignored unless `src_rst_i` is 0, `src_en_i` is 1 and `osc_en_i` is 1.
- R8: While `legacy_mode_i` is 1, a health-failure event is also ignored unless `health_unit_en_i` is 1. Test-failure events do not depend on these two inputs.
- R9: An event pulse in the same cycle as a control write that clears the same flag leaves the flag set.
- R10: A flag stays set until its clear bit is written. Changing its enable does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ictl_we_i | input | 1 | Control-word write strobe |
| ictl_wdata_i | input | 6 | Control write data: enables [2:0], clears [5:3] |
| isr_we_i | input | 1 | Status-word write strobe |
| isr_wdata_i | input | 2 | Write-1-to-clear data for the status word |
| ier_we_i | input | 1 | Mask-enable strobe |
| ier_wdata_i | input | 2 | Mask bits to clear |
| idr_we_i | input | 1 | Mask-disable strobe |
| idr_wdata_i | input | 2 | Mask bits to set |
| ev_done_i | input | 1 | Done event pulse |
| ev_dtest_fail_i | input | 1 | Deterministic-test failure pulse |
| ev_health_fail_i | input | 1 | Entropy-health failure pulse |
| slverr_i | input | 1 | Bus slave-error pulse |
| src_rst_i | input | 1 | Noise source held in reset |
| src_en_i | input | 1 | Noise source enable |
| osc_en_i | input | 1 | Oscillator enable |
| legacy_mode_i | input | 1 | Legacy version behaviour |
| health_unit_en_i | input | 1 | Health-test unit enable (legacy mode) |
| flags_o | output | 3 | Sticky flags: done, test failure, health failure |
| flag_en_o | output | 3 | Flag enables |
| isr_o | output | 2 | Status word: core [0], slave error [1] |
| imr_o | output | 2 | Mask word, 1 = masked |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets same-cycle collisions. An event that meets its own clear must leave the flag set, and a slave-error pulse that meets its write-1-to-clear must leave the bit set. A design where clear wins would drop events. It also writes the status core bit while an enabled flag is still set; a design that honours that write would lose the interrupt. Each of the three source qualifiers is dropped alone and the legacy health-unit gate is tested. A wrong gate would let a failure from an idle source through. The bench also checks that the mask cannot be cleared by a disable strobe, and that a disabled flag survives.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_FLAGS   = 3;
  localparam int ICTL_W      = 2 * NUM_FLAGS;
  localparam int ISR_W       = 2;
  localparam int FLAG_DONE   = 0;
  localparam int FLAG_DTEST  = 1;
  localparam int FLAG_HEALTH = 2;
  localparam int ISR_CORE    = 0;
  localparam int ISR_SLVERR  = 1;
  localparam logic [ISR_W-1:0] IMR_RESET = '1;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
  typedef logic [ISR_W-1:0]     isr_vec_t;
endpackage

// File: rtl/irq_agg_event_qual.sv
module irq_agg_event_qual
  import irq_agg_pkg::*;
(
  input  logic      ev_done_i,
  input  logic      ev_dtest_fail_i,
  input  logic      ev_health_fail_i,
  input  logic      src_rst_i,
  input  logic      src_en_i,
  input  logic      osc_en_i,
  input  logic      legacy_mode_i,
  input  logic      health_unit_en_i,
  output flag_vec_t ev_ok_o
);
  logic src_active;
  logic health_allowed;

  assign src_active     = !src_rst_i && src_en_i && osc_en_i;
  // legacy parts need the health-test unit explicitly enabled
  assign health_allowed = !legacy_mode_i || health_unit_en_i;

  always_comb begin
    ev_ok_o              = '0;
    ev_ok_o[FLAG_DONE]   = ev_done_i;
    ev_ok_o[FLAG_DTEST]  = ev_dtest_fail_i && src_active;
    ev_ok_o[FLAG_HEALTH] = ev_health_fail_i && src_active && health_allowed;
  end
endmodule

// File: rtl/irq_agg_flag_bank.sv
module irq_agg_flag_bank
  import irq_agg_pkg::*;
#(
  parameter int N = NUM_FLAGS,
  localparam int W = 2 * N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ictl_we_i,
  input  logic [W-1:0] ictl_wdata_i,
  input  logic [N-1:0] ev_set_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         core_d_o
);
  logic [N-1:0] flags_d;
  logic [N-1:0] en_d;

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic clr;
    assign clr        = ictl_we_i && ictl_wdata_i[N+g];
    // set has priority over a same-cycle clear
    assign flags_d[g] = ev_set_i[g] || (flags_o[g] && !clr);
    assign en_d[g]    = ictl_we_i ? ictl_wdata_i[g] : en_o[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_o[g] <= 1'b0;
        en_o[g]    <= 1'b0;
      end else begin
        flags_o[g] <= flags_d[g];
        en_o[g]    <= en_d[g];
      end
    end
  end

  assign core_d_o = |(flags_d & en_d);
endmodule

// File: rtl/irq_agg_mask_unit.sv
module irq_agg_mask_unit
  import irq_agg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     core_d_i,
  input  logic     slverr_i,
  input  logic     isr_we_i,
  input  isr_vec_t isr_wdata_i,
  input  logic     ier_we_i,
  input  isr_vec_t ier_wdata_i,
  input  logic     idr_we_i,
  input  isr_vec_t idr_wdata_i,
  output isr_vec_t isr_o,
  output isr_vec_t imr_o,
  output logic     irq_o
);
  isr_vec_t isr_d;
  isr_vec_t imr_d;
  isr_vec_t w1c;
  isr_vec_t ier_m;
  isr_vec_t idr_m;

  assign w1c   = isr_we_i ? isr_wdata_i : '0;
  assign ier_m = ier_we_i ? ier_wdata_i : '0;
  assign idr_m = idr_we_i ? idr_wdata_i : '0;

  always_comb begin
    isr_d             = '0;
    // core bit follows the aggregate; a clear cannot beat a live source
    isr_d[ISR_CORE]   = core_d_i;
    isr_d[ISR_SLVERR] = slverr_i || (isr_o[ISR_SLVERR] && !w1c[ISR_SLVERR]);
    imr_d             = (imr_o & ~ier_m) | idr_m;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_o <= '0;
      imr_o <= IMR_RESET;
      irq_o <= 1'b0;
    end else begin
      isr_o <= isr_d;
      imr_o <= imr_d;
      irq_o <= |(isr_d & ~imr_d);
    end
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ictl_we_i,
  input  logic [ICTL_W-1:0]    ictl_wdata_i,
  input  logic                 isr_we_i,
  input  logic [ISR_W-1:0]     isr_wdata_i,
  input  logic                 ier_we_i,
  input  logic [ISR_W-1:0]     ier_wdata_i,
  input  logic                 idr_we_i,
  input  logic [ISR_W-1:0]     idr_wdata_i,
  input  logic                 ev_done_i,
  input  logic                 ev_dtest_fail_i,
  input  logic                 ev_health_fail_i,
  input  logic                 slverr_i,
  input  logic                 src_rst_i,
  input  logic                 src_en_i,
  input  logic                 osc_en_i,
  input  logic                 legacy_mode_i,
  input  logic                 health_unit_en_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] flag_en_o,
  output logic [ISR_W-1:0]     isr_o,
  output logic [ISR_W-1:0]     imr_o,
  output logic                 irq_o
);
  flag_vec_t ev_ok;
  logic      core_d;

  irq_agg_event_qual u_qual (
    .ev_done_i        (ev_done_i),
    .ev_dtest_fail_i  (ev_dtest_fail_i),
    .ev_health_fail_i (ev_health_fail_i),
    .src_rst_i        (src_rst_i),
    .src_en_i         (src_en_i),
    .osc_en_i         (osc_en_i),
    .legacy_mode_i    (legacy_mode_i),
    .health_unit_en_i (health_unit_en_i),
    .ev_ok_o          (ev_ok)
  );

  irq_agg_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ictl_we_i    (ictl_we_i),
    .ictl_wdata_i (ictl_wdata_i),
    .ev_set_i     (ev_ok),
    .flags_o      (flags_o),
    .en_o         (flag_en_o),
    .core_d_o     (core_d)
  );

  irq_agg_mask_unit u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_d_i    (core_d),
    .slverr_i    (slverr_i),
    .isr_we_i    (isr_we_i),
    .isr_wdata_i (isr_wdata_i),
    .ier_we_i    (ier_we_i),
    .ier_wdata_i (ier_wdata_i),
    .idr_we_i    (idr_we_i),
    .idr_wdata_i (idr_wdata_i),
    .isr_o       (isr_o),
    .imr_o       (imr_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ictl_we_i,
  input logic [ICTL_W-1:0]    ictl_wdata_i,
  input logic                 isr_we_i,
  input logic [ISR_W-1:0]     isr_wdata_i,
  input logic                 ier_we_i,
  input logic [ISR_W-1:0]     ier_wdata_i,
  input logic                 idr_we_i,
  input logic [ISR_W-1:0]     idr_wdata_i,
  input logic                 ev_done_i,
  input logic                 ev_dtest_fail_i,
  input logic                 ev_health_fail_i,
  input logic                 slverr_i,
  input logic                 src_rst_i,
  input logic                 src_en_i,
  input logic                 osc_en_i,
  input logic                 legacy_mode_i,
  input logic                 health_unit_en_i,
  input logic [NUM_FLAGS-1:0] flags_o,
  input logic [NUM_FLAGS-1:0] flag_en_o,
  input logic [ISR_W-1:0]     isr_o,
  input logic [ISR_W-1:0]     imr_o,
  input logic                 irq_o
);
  AST_CORE_AGGREGATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_o[ISR_CORE] == |(flags_o & flag_en_o)); // R3

  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(isr_o & ~imr_o)); // R6

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ictl_we_i && ictl_wdata_i[NUM_FLAGS+FLAG_DONE] && ev_done_i) |=> flags_o[FLAG_DONE]); // R9

  AST_DTEST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_dtest_fail_i && src_rst_i && !flags_o[FLAG_DTEST]) |=> !flags_o[FLAG_DTEST]); // R7

  AST_LEGACY_HEALTH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_health_fail_i && legacy_mode_i && !health_unit_en_i && !flags_o[FLAG_HEALTH])
    |=> !flags_o[FLAG_HEALTH]); // R8

  AST_MASK_DISABLE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idr_we_i && idr_wdata_i[ISR_CORE]) |=> imr_o[ISR_CORE]); // R5

  AST_SLVERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slverr_i |=> isr_o[ISR_SLVERR]); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[FLAG_DONE] && !(ictl_we_i && ictl_wdata_i[NUM_FLAGS+FLAG_DONE]))
    |=> flags_o[FLAG_DONE]); // R10
endmodule

bind irq_agg_top irq_agg_chk u_chk (.*);

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;
  typedef struct packed {
    logic       ictl_we; logic [5:0] ictl_wd;
    logic       isr_we;  logic [1:0] isr_wd;
    logic       ier_we;  logic [1:0] ier_wd;
    logic       idr_we;  logic [1:0] idr_wd;
    logic [2:0] ev;      // {health, dtest, done}
    logic       slverr;
    logic [4:0] src;     // {src_rst, src_en, osc_en, legacy, health_unit_en}
    logic [2:0] x_flags; logic [2:0] x_en;
    logic [1:0] x_isr;   logic [1:0] x_imr;
    logic       x_irq;
  } vec_t;

  localparam logic [4:0] ON  = 5'b01100;
  localparam logic [4:0] RST = 5'b11100;
  localparam logic [4:0] LGN = 5'b01110;
  localparam logic [4:0] LGY = 5'b01111;
  localparam int NV = 15;

  localparam vec_t VECS [NV] = '{
    '{1'b0,6'h00,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b001,1'b0,ON ,3'b001,3'b000,2'b00,2'b11,1'b0}, // R7 done ungated
    '{1'b1,6'h01,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b000,1'b0,ON ,3'b001,3'b001,2'b01,2'b11,1'b0}, // R2 enable
    '{1'b0,6'h00,1'b0,2'b00,1'b1,2'b01,1'b0,2'b00,3'b000,1'b0,ON ,3'b001,3'b001,2'b01,2'b10,1'b1}, // R6 unmask
    '{1'b0,6'h00,1'b1,2'b01,1'b0,2'b00,1'b0,2'b00,3'b000,1'b0,ON ,3'b001,3'b001,2'b01,2'b10,1'b1}, // R3 w1c vs live
    '{1'b1,6'h09,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b000,1'b0,ON ,3'b000,3'b001,2'b00,2'b10,1'b0}, // R2 clear
    '{1'b0,6'h00,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b010,1'b0,RST,3'b000,3'b001,2'b00,2'b10,1'b0}, // R7 src reset
    '{1'b0,6'h00,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b010,1'b0,ON ,3'b010,3'b001,2'b00,2'b10,1'b0}, // R7 accepted
    '{1'b1,6'h03,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b000,1'b0,ON ,3'b010,3'b011,2'b01,2'b10,1'b1}, // R3 enable late
    '{1'b0,6'h00,1'b0,2'b00,1'b0,2'b00,1'b1,2'b01,3'b000,1'b0,ON ,3'b010,3'b011,2'b01,2'b11,1'b0}, // R5 disable
    '{1'b0,6'h00,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b000,1'b1,ON ,3'b010,3'b011,2'b11,2'b11,1'b0}, // R4 slverr
    '{1'b0,6'h00,1'b0,2'b00,1'b1,2'b10,1'b0,2'b00,3'b000,1'b0,ON ,3'b010,3'b011,2'b11,2'b01,1'b1}, // R6 slverr irq
    '{1'b0,6'h00,1'b1,2'b10,1'b0,2'b00,1'b0,2'b00,3'b000,1'b0,ON ,3'b010,3'b011,2'b01,2'b01,1'b0}, // R4 w1c
    '{1'b0,6'h00,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b100,1'b0,LGN,3'b010,3'b011,2'b01,2'b01,1'b0}, // R8 blocked
    '{1'b0,6'h00,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b100,1'b0,LGY,3'b110,3'b011,2'b01,2'b01,1'b0}, // R8 allowed
    '{1'b1,6'h30,1'b0,2'b00,1'b0,2'b00,1'b0,2'b00,3'b010,1'b0,ON ,3'b010,3'b000,2'b00,2'b01,1'b0}  // R9 event wins
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ictl_we = 0, isr_we = 0, ier_we = 0, idr_we = 0;
  logic [5:0] ictl_wd = '0;
  logic [1:0] isr_wd = '0, ier_wd = '0, idr_wd = '0;
  logic ev_done = 0, ev_dt = 0, ev_hf = 0, slverr = 0;
  logic src_rst = 0, src_en = 1, osc_en = 1, legacy = 0, hu_en = 0;
  logic [2:0] flags, fen;
  logic [1:0] isr, imr;
  logic irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_agg_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ictl_we_i(ictl_we), .ictl_wdata_i(ictl_wd),
    .isr_we_i(isr_we), .isr_wdata_i(isr_wd),
    .ier_we_i(ier_we), .ier_wdata_i(ier_wd),
    .idr_we_i(idr_we), .idr_wdata_i(idr_wd),
    .ev_done_i(ev_done), .ev_dtest_fail_i(ev_dt), .ev_health_fail_i(ev_hf),
    .slverr_i(slverr), .src_rst_i(src_rst), .src_en_i(src_en), .osc_en_i(osc_en),
    .legacy_mode_i(legacy), .health_unit_en_i(hu_en),
    .flags_o(flags), .flag_en_o(fen), .isr_o(isr), .imr_o(imr), .irq_o(irq)
  );

  function automatic string vec_req(int i);
    case (i)
      0, 5, 6: return "R7";
      1, 4:    return "R2";
      2, 10:   return "R6";
      3, 7:    return "R3";
      8:       return "R5";
      9, 11:   return "R4";
      12, 13:  return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req, logic [2:0] f, logic [2:0] e,
                             logic [1:0] s, logic [1:0] m, logic q);
    chk(req, "flags", flags, f);
    chk(req, "enables", fen, e);
    chk(req, "isr", {1'b0, isr}, {1'b0, s});
    chk(req, "imr", {1'b0, imr}, {1'b0, m});
    chk(req, "irq", {2'b0, irq}, {2'b0, q});
  endtask

  task automatic run_vec(vec_t v, string req);
    @(negedge clk);
    ictl_we = v.ictl_we; ictl_wd = v.ictl_wd;
    isr_we = v.isr_we;   isr_wd = v.isr_wd;
    ier_we = v.ier_we;   ier_wd = v.ier_wd;
    idr_we = v.idr_we;   idr_wd = v.idr_wd;
    {ev_hf, ev_dt, ev_done} = v.ev;
    slverr = v.slverr;
    {src_rst, src_en, osc_en, legacy, hu_en} = v.src;
    @(negedge clk);
    check_state(req, v.x_flags, v.x_en, v.x_isr, v.x_imr, v.x_irq);
    ictl_we = 0; isr_we = 0; ier_we = 0; idr_we = 0;
    {ev_hf, ev_dt, ev_done} = '0;
    slverr = 0;
  endtask

  function automatic vec_t mk(logic iw, logic [5:0] id, logic sw, logic [1:0] sd,
                              logic ew, logic [1:0] ed, logic dw, logic [1:0] dd,
                              logic [2:0] ev, logic se, logic [4:0] src,
                              logic [2:0] xf, logic [2:0] xe, logic [1:0] xs,
                              logic [1:0] xm, logic xq);
    vec_t v;
    v = '{iw, id, sw, sd, ew, ed, dw, dd, ev, se, src, xf, xe, xs, xm, xq};
    return v;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1", 3'b000, 3'b000, 2'b00, 2'b11, 1'b0); // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 3'b000, 3'b000, 2'b00, 2'b11, 1'b0); // R1 after release

    for (int i = 0; i < NV; i++) run_vec(VECS[i], vec_req(i));

    // R10: flag kept with enable 0, re-enabling raises core bit
    run_vec(mk(1,6'h02,0,0,0,0,0,0,3'b000,0,ON, 3'b010,3'b010,2'b01,2'b01,0), "R10");
    // R5: enable and disable on same cycle, disable wins for bit 1
    run_vec(mk(0,0,0,0,1,2'b11,1,2'b10,3'b000,0,ON, 3'b010,3'b010,2'b01,2'b10,1), "R5");
    // R2: clear test-failure flag, keep its enable
    run_vec(mk(1,6'h12,0,0,0,0,0,0,3'b000,0,ON, 3'b000,3'b010,2'b00,2'b10,0), "R2");
    // R7: source enable low
    run_vec(mk(0,0,0,0,0,0,0,0,3'b010,0,5'b00100, 3'b000,3'b010,2'b00,2'b10,0), "R7");
    // R7: oscillator enable low
    run_vec(mk(0,0,0,0,0,0,0,0,3'b010,0,5'b01000, 3'b000,3'b010,2'b00,2'b10,0), "R7");
    // R7: done accepted while source in reset
    run_vec(mk(0,0,0,0,0,0,0,0,3'b001,0,RST, 3'b001,3'b010,2'b00,2'b10,0), "R7");
    // R4: slave-error pulse beats same-cycle clear; bit 1 masked
    run_vec(mk(0,0,1,2'b10,0,0,0,0,3'b000,1,ON, 3'b001,3'b010,2'b10,2'b10,0), "R4");
    // R8: test-failure event unaffected by legacy gate
    run_vec(mk(0,0,0,0,0,0,0,0,3'b010,0,LGN, 3'b011,3'b010,2'b11,2'b10,1), "R8");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_state("R1", 3'b000, 3'b000, 2'b00, 2'b11, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 3'b000, 3'b000, 2'b00, 2'b11, 1'b0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule